// File: doc/BRIEF.md
# Wakeup and Standby Status Register

This block is a single 32-bit status register reached over APB for a low-power controller. It records three things: that a wakeup event happened, that the device went through standby, and the current level of a supply-voltage detector. It also holds the software enable for a dedicated wakeup pin. Hardware sets the two event flags. Strobes from a companion control register clear them.

Each field answers to its own reset domain. The power-on reset clears everything. The system reset clears the pin enable and the wakeup flag but leaves the standby flag alone, so that software can still see after the reboot that standby occurred.

The wakeup pin passes through a synchronizer. It is then gated by the enable and fed to a rising-edge detector. Turning the enable on while the pin is already high therefore counts as one more event. A pulse output repeats the wakeup-flag set condition for the standby sequencer. Reads are slower than standard APB reads: they always take two wait states. Writes complete with no wait states.

Top module: `wkup_stat_reg`

## Requirements
- R1: After a power-on reset (`por_ni` low), a read of offset 0x04 returns 0.
- R2: At offset 0x04, bit 0 is the wakeup flag, bit 1 is the standby flag, bit 2 is the detector output and bit 8 is the pin enable. All other bits read 0. A read of any other offset returns 0.
- R3: Software can write bit 8 at offset 0x04. Writes to other bits of that offset, and writes to any other offset, change nothing.
- R4: While the enable is set, a rising pin level sets the wakeup flag. The pin must be high before clock edge k, and the flag reads 1 from edge k+2.
- R5: While the enable is clear, pin activity never sets the wakeup flag.
- R6: Writing the enable to 1 while the pin is already high sets the wakeup flag at the next edge after the write completes.
- R7: An `rtc_alarm_i` pulse sets the wakeup flag at that edge, whatever the enable is.
- R8: `clr_wuf_i` clears the wakeup flag. When it coincides with a set condition, the flag ends at 1.
- R9: `stby_enter_i` sets the standby flag. It is cleared only by `clr_sbf_i` (a simultaneous set wins) or by a power-on reset.
- R10: A system reset (`rst_ni` low with `por_ni` high) clears the enable and the wakeup flag and keeps the standby flag.
- R11: Bit 2 equals `vdet_out_i & vdet_en_i`, so it reads 0 while the detector is disabled.
- R12: Reads hold `pready_o` low for the first two access cycles. Writes complete in the first access cycle. `pslverr_o` is always 0.
- R13: `wkup_req_o` is high exactly in the cycles in which the wakeup flag's set condition holds: an edge on the enabled, synchronized pin, or an RTC alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, asynchronous, active low |
| por_ni | input | 1 | Power-on/power-down reset, asynchronous, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready |
| pslverr_o | output | 1 | APB error, always 0 |
| wkup_pin_i | input | 1 | Raw wakeup pin level, asynchronous |
| rtc_alarm_i | input | 1 | RTC alarm pulse |
| stby_enter_i | input | 1 | Standby entry indication |
| vdet_out_i | input | 1 | Voltage detector result, 1 = below threshold |
| vdet_en_i | input | 1 | Voltage detector enable |
| clr_wuf_i | input | 1 | Clear strobe for the wakeup flag |
| clr_sbf_i | input | 1 | Clear strobe for the standby flag |
| wkup_req_o | output | 1 | Wakeup request pulse |

## Verification
A pin change reaches `wkup_req_o` two edges later, after the synchronizer, and reaches the flag one edge after that. An RTC alarm, a strobe or an enable write shows in the register at the edge where it is sampled. Read data appears in the third access cycle, when `pready_o` rises. The bench drives inputs on falling edges and compares the request pulse and `pslverr_o` with its model 1 ns after every falling edge. It also compares each read's data and wait count with the model at the cycle `pready_o` is seen high. Directed checks sample the pulse at the second falling edge after a pin change and one falling edge earlier, to pin down the exact latency.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned WUF_BIT = 0;
  localparam int unsigned SBF_BIT = 1;
  localparam int unsigned PVD_BIT = 2;
  localparam int unsigned EN_BIT  = 8;
  localparam int unsigned REG_OFFS = 4;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/wkup_flags.sv
module wkup_flags (
  input  logic clk_i,
  input  logic sys_rst_ni,
  input  logic por_ni,
  input  logic pin_sync_i,
  input  logic rtc_alarm_i,
  input  logic stby_enter_i,
  input  logic clr_wuf_i,
  input  logic clr_sbf_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  output logic en_o,
  output logic wuf_o,
  output logic sbf_o,
  output logic wake_set_o
);
  logic en_q, gated_prev_q, wuf_q, sbf_q;
  logic gated, pin_rise;

  // enable-gated level: enabling over a high pin looks like an edge
  assign gated      = pin_sync_i & en_q;
  assign pin_rise   = gated & ~gated_prev_q;
  assign wake_set_o = pin_rise | rtc_alarm_i;

  always_ff @(posedge clk_i or negedge sys_rst_ni)
    if (!sys_rst_ni) begin
      en_q         <= 1'b0;
      gated_prev_q <= 1'b0;
      wuf_q        <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= en_wdata_i;
      gated_prev_q <= gated;
      if (wake_set_o)     wuf_q <= 1'b1;
      else if (clr_wuf_i) wuf_q <= 1'b0;
    end

  // standby flag survives system reset
  always_ff @(posedge clk_i or negedge por_ni)
    if (!por_ni)           sbf_q <= 1'b0;
    else if (stby_enter_i) sbf_q <= 1'b1;
    else if (clr_sbf_i)    sbf_q <= 1'b0;

  assign en_o  = en_q;
  assign wuf_o = wuf_q;
  assign sbf_o = sbf_q;

  p_wuf_set_wins_r8: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    wake_set_o |=> wuf_q)
    else $error("wakeup set lost");
  p_wuf_clear_r8: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    (clr_wuf_i && !wake_set_o) |=> !wuf_q)
    else $error("wakeup clear ignored");
  p_sbf_set_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    stby_enter_i |=> sbf_q)
    else $error("standby set lost");
  p_sbf_hold_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!stby_enter_i && !clr_sbf_i) |=> $stable(sbf_q))
    else $error("standby flag moved");
  p_en_off_no_pin_r5: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    (!en_q && !en_wr_i && !rtc_alarm_i && !wuf_q) |=> !wake_set_o || rtc_alarm_i)
    else $error("pin event while disabled");
endmodule

// File: rtl/wkup_apb.sv
module wkup_apb
  import wkup_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned RD_WAIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] reg_val_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              reg_wr_o
);
  localparam int unsigned CNT_W = $clog2(RD_WAIT + 2);
  localparam logic [CNT_W-1:0] WAIT_C = CNT_W'(RD_WAIT);
  localparam logic [ADDR_W-1:0] OFFS_C = ADDR_W'(REG_OFFS);

  logic [CNT_W-1:0] cnt_q;
  logic rd_acc, rd_done, hit;

  assign hit     = (paddr_i == OFFS_C);
  assign rd_acc  = psel_i & penable_i & ~pwrite_i;
  assign rd_done = (cnt_q == WAIT_C);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                cnt_q <= '0;
    else if (rd_acc && !rd_done) cnt_q <= cnt_q + 1'b1;
    else                        cnt_q <= '0;

  assign pready_o = ~rd_acc | rd_done;
  assign prdata_o = (rd_acc && rd_done && hit) ? reg_val_i : '0;
  assign reg_wr_o = psel_i & penable_i & pwrite_i & hit;

  p_wr_nowait_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && pwrite_i) |-> pready_o)
    else $error("write stalled");
  p_rd_first_wait_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && $rose(penable_i) && !pwrite_i) |-> !pready_o)
    else $error("read ready too early");
endmodule

// File: rtl/wkup_stat_reg.sv
module wkup_stat_reg
  import wkup_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned RD_WAIT     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              wkup_pin_i,
  input  logic              rtc_alarm_i,
  input  logic              stby_enter_i,
  input  logic              vdet_out_i,
  input  logic              vdet_en_i,
  input  logic              clr_wuf_i,
  input  logic              clr_sbf_i,
  output logic              wkup_req_o
);
  logic sys_rst_n, pin_sync, reg_wr;
  logic en, wuf, sbf;
  logic [DATA_W-1:0] reg_val;

  assign sys_rst_n = rst_ni & por_ni;

  wkup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(sys_rst_n),
    .d_i   (wkup_pin_i),
    .q_o   (pin_sync)
  );

  wkup_flags u_flags (
    .clk_i       (clk_i),
    .sys_rst_ni  (sys_rst_n),
    .por_ni      (por_ni),
    .pin_sync_i  (pin_sync),
    .rtc_alarm_i (rtc_alarm_i),
    .stby_enter_i(stby_enter_i),
    .clr_wuf_i   (clr_wuf_i),
    .clr_sbf_i   (clr_sbf_i),
    .en_wr_i     (reg_wr),
    .en_wdata_i  (pwdata_i[EN_BIT]),
    .en_o        (en),
    .wuf_o       (wuf),
    .sbf_o       (sbf),
    .wake_set_o  (wkup_req_o)
  );

  always_comb begin
    reg_val          = '0;
    reg_val[WUF_BIT] = wuf;
    reg_val[SBF_BIT] = sbf;
    reg_val[PVD_BIT] = vdet_out_i & vdet_en_i;
    reg_val[EN_BIT]  = en;
  end

  wkup_apb #(.ADDR_W(ADDR_W), .RD_WAIT(RD_WAIT)) u_apb (
    .clk_i    (clk_i),
    .rst_ni   (sys_rst_n),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .reg_val_i(reg_val),
    .prdata_o (prdata_o),
    .pready_o (pready_o),
    .reg_wr_o (reg_wr)
  );

  assign pslverr_o = 1'b0;

  p_sys_rst_keeps_sbf_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!rst_ni && !stby_enter_i && !clr_sbf_i) |=> $stable(sbf))
    else $error("system reset touched standby flag");
  p_req_sets_flag_r13: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    wkup_req_o |=> wuf)
    else $error("request without flag");
endmodule

// File: tb/wkup_stat_reg_tb.sv
module wkup_stat_reg_tb;
  localparam int AW = 8;

  logic clk = 0;
  logic rst_n = 0, por_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic pin = 0, rtc = 0, stby = 0, vout = 0, ven = 0, cwuf = 0, csbf = 0;
  logic wreq;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  wkup_stat_reg #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite), .paddr_i(paddr),
    .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .wkup_pin_i(pin), .rtc_alarm_i(rtc), .stby_enter_i(stby),
    .vdet_out_i(vout), .vdet_en_i(ven), .clr_wuf_i(cwuf), .clr_sbf_i(csbf),
    .wkup_req_o(wreq)
  );

  // behavioural reference
  int m_s1, m_s2, m_en, m_prev, m_wuf, m_sbf;
  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n) begin
      m_s1 = 0; m_s2 = 0; m_en = 0; m_prev = 0; m_wuf = 0; m_sbf = 0;
    end else if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_en = 0; m_prev = 0; m_wuf = 0;
    end else begin
      int g, setw;
      g = m_s2 && m_en;
      setw = (g && !m_prev) || rtc;
      m_prev = g;
      m_s2 = m_s1;
      m_s1 = pin;
      if (setw) m_wuf = 1; else if (cwuf) m_wuf = 0;
      if (stby) m_sbf = 1; else if (csbf) m_sbf = 0;
      if (psel && penable && pwrite && paddr == 8'h04) m_en = pwdata[8];
    end
  end

  function automatic int exp_req();
    return ((m_s2 && m_en && !m_prev) || rtc) ? 1 : 0;
  endfunction

  function automatic logic [31:0] exp_reg();
    logic [31:0] v = '0;
    v[0] = m_wuf[0]; v[1] = m_sbf[0]; v[2] = vout & ven; v[8] = m_en[0];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n && por_n && !done) begin
      check("R13 req", {31'b0, wreq}, exp_req());
      check("R12 pslverr", {31'b0, pslverr}, 32'h0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1;
    check("R12 write no wait", {31'b0, pready}, 32'h1);
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [AW-1:0] a, input string req);
    int waits = 0;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    forever begin
      #1;
      if (pready) break;
      waits++;
      if (waits > 10) break;
      @(negedge clk);
    end
    check("R12 read waits", waits, 2);
    check(req, prdata, (a == 8'h04) ? exp_reg() : 32'h0);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(2);
    por_n = 1; rst_n = 1;
    idle(1);
    apb_rd(8'h04, "R1 reset value");
    check("R1 literal", exp_reg(), 32'h0);

    // R3: only bit 8 writable; other offsets ignored
    apb_wr(8'h04, 32'hFFFF_FFFF);
    apb_rd(8'h04, "R3 enable write");
    check("R3 literal", exp_reg(), 32'h100);
    apb_wr(8'h08, 32'h0);
    apb_rd(8'h04, "R3 other offset ignored");
    apb_rd(8'h08, "R2 other offset reads zero");

    // R4/R13 latency with enable on
    @(negedge clk); pin = 1;
    @(negedge clk); #1; check("R13 req not yet", {31'b0, wreq}, 32'h0);
    @(negedge clk); #1; check("R13 req due", {31'b0, wreq}, 32'h1);
    apb_rd(8'h04, "R4 pin edge sets flag");
    check("R4 literal", exp_reg(), 32'h101);

    // R8 clear, then clear colliding with alarm
    @(negedge clk); cwuf = 1; @(negedge clk); cwuf = 0;
    apb_rd(8'h04, "R8 clear");
    @(negedge clk); cwuf = 1; rtc = 1; @(negedge clk); cwuf = 0; rtc = 0;
    apb_rd(8'h04, "R8 set wins");
    @(negedge clk); cwuf = 1; @(negedge clk); cwuf = 0;

    // R5 disabled pin
    apb_wr(8'h04, 32'h0);
    @(negedge clk); pin = 0; idle(4); pin = 1; idle(4);
    apb_rd(8'h04, "R5 disabled pin ignored");
    check("R5 literal", exp_reg(), 32'h0);

    // R6 enable while pin high
    apb_wr(8'h04, 32'h100);
    apb_rd(8'h04, "R6 enable over high pin");
    check("R6 literal", exp_reg(), 32'h101);
    @(negedge clk); cwuf = 1; @(negedge clk); cwuf = 0;
    apb_wr(8'h04, 32'h0);

    // R7 alarm with enable off
    @(negedge clk); rtc = 1; @(negedge clk); rtc = 0;
    apb_rd(8'h04, "R7 alarm");

    // R9 standby flag
    @(negedge clk); stby = 1; @(negedge clk); stby = 0;
    apb_rd(8'h04, "R9 standby set");
    @(negedge clk); stby = 1; csbf = 1; @(negedge clk); stby = 0; csbf = 0;
    apb_rd(8'h04, "R9 standby set wins");
    apb_wr(8'h04, 32'h100);

    // R10 system reset keeps standby flag
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    apb_rd(8'h04, "R10 system reset");
    check("R10 literal", exp_reg(), 32'h2);
    @(negedge clk); csbf = 1; @(negedge clk); csbf = 0;
    apb_rd(8'h04, "R9 standby clear");
    @(negedge clk); stby = 1; @(negedge clk); stby = 0;
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
    apb_rd(8'h04, "R1 power-on reset");

    // R11 detector gating
    vout = 1; ven = 0; apb_rd(8'h04, "R11 detector disabled");
    ven = 1;            apb_rd(8'h04, "R11 detector low supply");
    check("R11 literal", exp_reg(), 32'h4);
    vout = 0;           apb_rd(8'h04, "R11 detector ok");

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule